// File: doc/BRIEF.md
# DTMF Digit Serial Reporter

This block turns one qualified telephone keypad event into a short asynchronous serial report. The key is given as a position in the 4x4 keypad grid. The row index selects the low-group tone, in ascending order 697, 770, 852 and 941 Hz. The column index selects the high-group tone, in ascending order 1209, 1336, 1477 and 1633 Hz.

The block maps the key to a 4-bit code and computes a 4-bit checksum whose sum with the code is zero modulo 16. It first pulls an active-low data-valid strobe. After a fixed lead time it shifts out a 10-bit frame at 1200 baud on a line that otherwise rests high.

A host receiver uses the strobe as its cue to expect a frame. The busy flag tells the upstream tone validator that a new key would be dropped. Power-down forces both output lines high and abandons any frame in flight.

Top module: `dtmf_serial_reporter`

## Requirements
- R1: After reset, ser_out is 1, dv_n is 1 and busy is 0.
- R2: The 4-bit code depends on the key position. Keypad rows 0..3 read "1 2 3 A", "4 5 6 B", "7 8 9 C" and "* 0 # D", with column 0 on the left. Digits 1-9 give binary 1-9. The digit 0 gives 10, * gives 11, # gives 12, A gives 13, B gives 14, C gives 15 and D gives 0.
- R3: The checksum nibble equals (16 - code) mod 16, so code 0 gives 0.
- R4: The frame, in send order, is a 0 start bit, then code bits 0..3, then checksum bits 0..3, then a 1 stop bit.
- R5: Every frame bit lasts BIT_CYCLES clocks. The default is 2983, which at 3.579545 MHz is 1200 baud within 1%.
- R6: A key_valid sampled while idle and not powered down drives dv_n low on the next clock. The start bit begins LEAD_CYCLES clocks after that edge. The default of 3580 is about 1 ms, under the 5 ms limit.
- R7: dv_n stays 0 and busy stays 1 from acceptance until the stop bit has lasted its full period. Both return to idle on that same edge.
- R8: When no frame is being sent, ser_out is 1.
- R9: A key_valid that arrives while busy is 1 is dropped. It does not alter the frame in flight, and no second frame follows.
- R10: While pwr_down is 1, ser_out and dv_n are 1, busy is 0 and key_valid is dropped. A frame cut off by power-down is not resumed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, nominally 3.579545 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down | input | 1 | Power-down request, active high |
| key_valid | input | 1 | One-cycle pulse marking a qualified key |
| key_row | input | 2 | Low-group row index, 0 = 697 Hz |
| key_col | input | 2 | High-group column index, 0 = 1209 Hz |
| ser_out | output | 1 | Serial frame output, rests high |
| dv_n | output | 1 | Active-low data-valid strobe |
| busy | output | 1 | High while a report is in progress |

## Verification
All sixteen grid positions are sent. They cover the digits whose code is their face value, the zero, star and hash keys with their shifted codes, the letter column with its wrap to code 0, and the D key whose checksum is also 0. The received bits are taken cycle by cycle. A wrong bit period or lead time shows up apart from a wrong code or checksum, and a misplaced start or stop bit shows up apart from both. Two further runs isolate the drop rules. One sends a second key in mid-frame and another on the final busy cycle. The other applies power-down in mid-frame, pulses a key during it, then releases it.

// File: rtl/dtmf_rep_pkg.sv
package dtmf_rep_pkg;

  localparam int FRAME_BITS = 10;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_SEND = 2'd2
  } rep_state_e;

  // grid position to reported code
  function automatic logic [3:0] key_to_code(input logic [1:0] row, input logic [1:0] col);
    logic [3:0] r4;
    logic [3:0] c4;
    r4 = {2'b00, row};
    c4 = {2'b00, col};
    if (col == 2'd3) begin
      case (row)
        2'd0:    key_to_code = 4'd13;
        2'd1:    key_to_code = 4'd14;
        2'd2:    key_to_code = 4'd15;
        default: key_to_code = 4'd0;
      endcase
    end else if (row != 2'd3) begin
      key_to_code = r4 * 4'd3 + c4 + 4'd1;
    end else begin
      case (col)
        2'd0:    key_to_code = 4'd11;
        2'd1:    key_to_code = 4'd10;
        default: key_to_code = 4'd12;
      endcase
    end
  endfunction

  // two's-complement nibble: code + checksum wraps to zero
  function automatic logic [3:0] code_checksum(input logic [3:0] code);
    code_checksum = 4'd0 - code;
  endfunction

  // bit 0 leaves first
  function automatic logic [FRAME_BITS-1:0] make_frame(input logic [3:0] code,
                                                       input logic [3:0] chk);
    make_frame = {1'b1, chk, code, 1'b0};
  endfunction

endpackage

// File: rtl/dtmf_key_encoder.sv
module dtmf_key_encoder
  import dtmf_rep_pkg::*;
(
  input  logic [1:0] row,
  input  logic [1:0] col,
  output logic [3:0] code,
  output logic [3:0] chk
);

  assign code = key_to_code(row, col);
  assign chk  = code_checksum(code);

  always_comb begin
    AST_CHECKSUM_ZERO_SUM: assert (4'(code + chk) == 4'd0); // R3
  end

endmodule

// File: rtl/dtmf_bit_timer.sv
module dtmf_bit_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic [W-1:0] limit,
  output logic         tick
);

  logic [W-1:0] cnt;

  assign tick = (cnt == limit - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clear)  cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + W'(1);
  end

  AST_TIMER_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < limit); // R5

endmodule

// File: rtl/dtmf_frame_shifter.sv
module dtmf_frame_shifter
  import dtmf_rep_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [FRAME_BITS-1:0] frame_in,
  input  logic                  advance,
  output logic                  bit_out,
  output logic                  last_bit
);

  localparam int IW = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] frame_q;
  logic [IW-1:0]         idx_q;

  assign bit_out  = frame_q[0];
  assign last_bit = (idx_q == IW'(FRAME_BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '1;
      idx_q   <= '0;
    end else if (load) begin
      frame_q <= frame_in;
      idx_q   <= '0;
    end else if (advance) begin
      frame_q <= {1'b1, frame_q[FRAME_BITS-1:1]};
      idx_q   <= idx_q + IW'(1);
    end
  end

  AST_IDX_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IW'(FRAME_BITS - 1)); // R4

  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !advance) |=> $stable(frame_q)); // R9

endmodule

// File: rtl/dtmf_serial_reporter.sv
module dtmf_serial_reporter
  import dtmf_rep_pkg::*;
#(
  parameter int BIT_CYCLES  = 2983,
  parameter int LEAD_CYCLES = 3580
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwr_down,
  input  logic       key_valid,
  input  logic [1:0] key_row,
  input  logic [1:0] key_col,
  output logic       ser_out,
  output logic       dv_n,
  output logic       busy
);

  localparam int MAX_CYC = (BIT_CYCLES > LEAD_CYCLES) ? BIT_CYCLES : LEAD_CYCLES;
  localparam int TW      = $clog2(MAX_CYC + 1);

  rep_state_e state_q;

  logic [3:0]            key_code;
  logic [3:0]            key_chk;
  logic [FRAME_BITS-1:0] frame_word;
  logic                  tick;
  logic [TW-1:0]         period;
  logic                  bit_out;
  logic                  last_bit;

  // named events for the checks
  logic accept;
  logic start_evt;
  logic advance;
  logic finish_evt;

  dtmf_key_encoder u_enc (
    .row  (key_row),
    .col  (key_col),
    .code (key_code),
    .chk  (key_chk)
  );

  assign frame_word = make_frame(key_code, key_chk);
  assign period     = (state_q == ST_LEAD) ? TW'(LEAD_CYCLES) : TW'(BIT_CYCLES);

  dtmf_bit_timer #(.W(TW)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (state_q == ST_IDLE),
    .limit (period),
    .tick  (tick)
  );

  assign accept     = key_valid && !pwr_down && (state_q == ST_IDLE);
  assign start_evt  = !pwr_down && (state_q == ST_LEAD) && tick;
  assign advance    = !pwr_down && (state_q == ST_SEND) && tick && !last_bit;
  assign finish_evt = !pwr_down && (state_q == ST_SEND) && tick && last_bit;

  dtmf_frame_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .frame_in (frame_word),
    .advance  (advance),
    .bit_out  (bit_out),
    .last_bit (last_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                state_q <= ST_IDLE;
    else if (pwr_down)         state_q <= ST_IDLE;
    else if (accept)           state_q <= ST_LEAD;
    else if (start_evt)        state_q <= ST_SEND;
    else if (finish_evt)       state_q <= ST_IDLE;
  end

  assign ser_out = pwr_down || (state_q != ST_SEND) || bit_out;
  assign dv_n    = pwr_down || (state_q == ST_IDLE);
  assign busy    = !pwr_down && (state_q != ST_IDLE);

  AST_PDWN_LINES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |-> (ser_out && dv_n && !busy)); // R10

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ser_out); // R8

  AST_DV_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n || pwr_down)
    accept |=> (!dv_n && busy)); // R6

  AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n || pwr_down)
    start_evt |=> !ser_out); // R4

  AST_STOP_BIT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_SEND) && last_bit) |-> ser_out); // R4

  AST_RELEASE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n || pwr_down)
    finish_evt |=> (dv_n && !busy)); // R7

  AST_BUSY_DROPS_KEY: assert property (@(posedge clk) disable iff (!rst_n || pwr_down)
    (busy && key_valid && !finish_evt) |=> busy); // R9

endmodule

// File: tb/tb_dtmf_serial_reporter.sv
`timescale 1ns/1ps
module tb_dtmf_serial_reporter;

  localparam int BITC  = 8;
  localparam int LEADC = 5;
  localparam int FRAME_CYC = LEADC + 10 * BITC;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pwr_down = 1'b0;
  logic       key_valid = 1'b0;
  logic [1:0] key_row = 2'd0;
  logic [1:0] key_col = 2'd0;
  logic       ser_out;
  logic       dv_n;
  logic       busy;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // {row, col, expected code}
  localparam logic [7:0] VEC [0:15] = '{
    {2'd0, 2'd0, 4'd1},  {2'd0, 2'd1, 4'd2},  {2'd0, 2'd2, 4'd3},  {2'd0, 2'd3, 4'd13},
    {2'd1, 2'd0, 4'd4},  {2'd1, 2'd1, 4'd5},  {2'd1, 2'd2, 4'd6},  {2'd1, 2'd3, 4'd14},
    {2'd2, 2'd0, 4'd7},  {2'd2, 2'd1, 4'd8},  {2'd2, 2'd2, 4'd9},  {2'd2, 2'd3, 4'd15},
    {2'd3, 2'd0, 4'd11}, {2'd3, 2'd1, 4'd10}, {2'd3, 2'd2, 4'd12}, {2'd3, 2'd3, 4'd0}
  };

  dtmf_serial_reporter #(.BIT_CYCLES(BITC), .LEAD_CYCLES(LEADC)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_down  (pwr_down),
    .key_valid (key_valid),
    .key_row   (key_row),
    .key_col   (key_col),
    .ser_out   (ser_out),
    .dv_n      (dv_n),
    .busy      (busy)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // sends one key and follows the whole report cycle by cycle
  task automatic run_frame(input logic [1:0] r, input logic [1:0] c,
                           input int exp_code, input int inject_at);
    int exp_chk;
    logic [9:0] exp_bits;
    logic [9:0] rx;
    int line_err;
    int strobe_err;
    exp_chk  = (16 - exp_code) % 16;
    exp_bits = {1'b1, 4'(exp_chk), 4'(exp_code), 1'b0};
    rx = '0;
    line_err = 0;
    strobe_err = 0;
    @(negedge clk);
    key_row = r; key_col = c; key_valid = 1'b1;
    @(negedge clk);
    key_valid = 1'b0;
    check(!dv_n && busy && ser_out, "R6 strobe after accept", {dv_n, busy, ser_out}, 3'b011);
    for (int n = 1; n <= FRAME_CYC + 1; n++) begin
      int exp_line;
      int exp_dvn;
      if (n == inject_at) begin
        key_row = ~r; key_col = ~c; key_valid = 1'b1;
      end
      @(negedge clk);
      key_valid = 1'b0;
      if (n < LEADC) exp_line = 1;
      else if (n < FRAME_CYC) exp_line = int'(exp_bits[(n - LEADC) / BITC]);
      else exp_line = 1;
      exp_dvn = (n < FRAME_CYC) ? 0 : 1;
      if (int'(ser_out) != exp_line) line_err++;
      if (int'(dv_n) != exp_dvn || int'(busy) == exp_dvn) strobe_err++;
      if (n >= LEADC && n < FRAME_CYC && ((n - LEADC) % BITC) == BITC / 2)
        rx[(n - LEADC) / BITC] = ser_out;
    end
    check(line_err == 0, "R5 bit timing per cycle", line_err, 0);
    check(strobe_err == 0, "R7 dv_n/busy span", strobe_err, 0);
    check(int'(rx[4:1]) == exp_code, "R2 code", int'(rx[4:1]), exp_code);
    check(int'(rx[8:5]) == exp_chk, "R3 checksum", int'(rx[8:5]), exp_chk);
    check(rx[0] == 1'b0 && rx[9] == 1'b1, "R4 start/stop", {rx[9], rx[0]}, 2);
  endtask

  task automatic quiet_span(input int cycles, input string req);
    int err;
    err = 0;
    for (int n = 0; n < cycles; n++) begin
      @(negedge clk);
      if (!ser_out || !dv_n || busy) err++;
    end
    check(err == 0, req, err, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(ser_out && dv_n && !busy, "R1 reset state", {ser_out, dv_n, busy}, 3'b110);
    rst_n = 1'b1;
    @(negedge clk);
    check(ser_out && dv_n && !busy, "R1 after reset release", {ser_out, dv_n, busy}, 3'b110);

    // table walk over all sixteen keys
    for (int i = 0; i < 16; i++) begin
      run_frame(VEC[i][7:6], VEC[i][5:4], int'(VEC[i][3:0]), -1);
      quiet_span(2, "R8 line idle between frames");
    end

    // R9: second key mid-frame is dropped
    run_frame(2'd0, 2'd0, 1, LEADC + 3);
    quiet_span(3 * BITC, "R9 no frame after mid-frame key");

    // R9: key on the final busy cycle is also dropped
    run_frame(2'd1, 2'd1, 5, FRAME_CYC);
    quiet_span(3 * BITC, "R9 no frame after last-cycle key");

    // R10: power-down in mid-frame
    @(negedge clk);
    key_row = 2'd2; key_col = 2'd2; key_valid = 1'b1;
    @(negedge clk);
    key_valid = 1'b0;
    repeat (LEADC + BITC + 2) @(negedge clk);
    pwr_down = 1'b1;
    #1;
    check(ser_out && dv_n && !busy, "R10 outputs high in power-down",
          {ser_out, dv_n, busy}, 3'b110);
    @(negedge clk);
    key_row = 2'd0; key_col = 2'd1; key_valid = 1'b1;
    @(negedge clk);
    key_valid = 1'b0;
    quiet_span(2 * BITC, "R10 power-down holds lines and drops key");
    pwr_down = 1'b0;
    quiet_span(3 * BITC, "R10 aborted frame not resumed");
    run_frame(2'd3, 2'd1, 10, -1);

    finish_run();
  end

endmodule